// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block sits in front of a synchronous memory array and steps it into and out of a low-power sleep state. An asynchronous sleep pin is resynchronized to the clock. Once the request is seen, the block fences off host accesses, counts a fixed entry latency and then reports that the memory is asleep. When the pin is released, it counts a fixed exit latency and then a recovery window before host selects are accepted again. The array contents are not touched at any point. Only an access that is still in flight at the moment of entry is reported as invalid.

The host side provides a chip-select and an access-request strobe. An access is accepted only while the block is awake. Two protocol faults are reported as single-cycle pulses: a select that is still active when the sleep request is first seen, and a select that arrives while the block is exiting or recovering. The sequence always runs to completion. A request that drops during entry still ends in a full sleep followed by a full exit.

Top module: `nap_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the state is awake and every output (`block_o`, `sleep_o`, `invalid_o`, `entry_viol_o`, `recov_viol_o`) is 0.
- R2: The sleep pin passes through a two-stage synchronizer. When the pin is high before clock edge k, `block_o` rises after edge k+2 and not before.
- R3: Entry lasts ENTRY_CYC cycles (2 by default). `sleep_o` rises exactly ENTRY_CYC edges after `block_o` rises.
- R4: When the pin is low before edge k of a sleep period, `sleep_o` falls after edge k+2. The block then spends EXIT_CYC exit cycles and RECOV_CYC recovery cycles, so `block_o` falls EXIT_CYC+RECOV_CYC edges (4 by default) after `sleep_o` falls.
- R5: `block_o` is 1 in every state except awake, and `sleep_o` is 1 only in the asleep state.
- R6: An access is `sel_i` and `req_i` both high while awake. An access made in the cycle the request is first seen, or in the cycle before it, raises `invalid_o` for exactly one cycle, in the first entry cycle. An access two or more cycles earlier does not raise it.
- R7: If `sel_i` is high in the awake cycle in which the synchronized request is first seen, `entry_viol_o` pulses for one cycle in the first entry cycle.
- R8: `sel_i` high in an exit or recovery cycle raises `recov_viol_o` on the next cycle for one cycle. `sel_i` while asleep or awake never raises it.
- R9: If the pin drops during entry, entry still completes to asleep for at least one cycle. The full exit and recovery sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin_i | input | 1 | Raw asynchronous sleep request |
| sel_i | input | 1 | Host chip-select (active high) |
| req_i | input | 1 | Host access request strobe |
| block_o | output | 1 | Host accesses are refused |
| sleep_o | output | 1 | Memory is in the sleep state |
| invalid_o | output | 1 | Pulse: access in flight at entry is invalid |
| entry_viol_o | output | 1 | Pulse: select active when request was seen |
| recov_viol_o | output | 1 | Pulse: select during exit or recovery |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and two cycles each for entry, exit and recovery. These settings make every edge-count expectation in the requirements concrete and short. A single test can then place a host access in the decision cycle, in the cycle before it, or two cycles earlier. It can also drop the pin in the middle of entry and land selects in each exit and recovery cycle.

// File: rtl/nap_pkg.sv
package nap_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_ENTER  = 3'd1,
        ST_ASLEEP = 3'd2,
        ST_EXIT   = 3'd3,
        ST_RECOV  = 3'd4
    } nap_state_e;
endpackage

// File: rtl/nap_sync.sv
module nap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/nap_inflight.sv
module nap_inflight (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic pending_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = accept_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
    import nap_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_i,
    input  logic sel_i,
    input  logic req_i,
    input  logic pending_i,
    output logic accept_o,
    output logic block_o,
    output logic sleep_o,
    output logic invalid_o,
    output logic entry_viol_o,
    output logic recov_viol_o
);
    localparam int MAXC = (ENTRY_CYC > EXIT_CYC)
                        ? ((ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC)
                        : ((EXIT_CYC > RECOV_CYC) ? EXIT_CYC : RECOV_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ENT_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EX_LD  = CW'(EXIT_CYC - 1);
    localparam logic [CW-1:0] RC_LD  = CW'(RECOV_CYC - 1);

    typedef struct packed {
        nap_state_e    st;
        logic [CW-1:0] cnt;
        logic          inval;
        logic          eviol;
        logic          rviol;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.inval = 1'b0;
        st_d.eviol = 1'b0;
        st_d.rviol = 1'b0;
        accept_o   = (st_q.st == ST_AWAKE) && sel_i && req_i;
        case (st_q.st)
            ST_AWAKE: begin
                if (req_s_i) begin
                    st_d.st    = ST_ENTER;
                    st_d.cnt   = ENT_LD;
                    st_d.inval = accept_o || pending_i;
                    st_d.eviol = sel_i;
                end
            end
            ST_ENTER: begin
                if (st_q.cnt == '0) st_d.st  = ST_ASLEEP;
                else                st_d.cnt = st_q.cnt - CW'(1);
            end
            ST_ASLEEP: begin
                if (!req_s_i) begin
                    st_d.st  = ST_EXIT;
                    st_d.cnt = EX_LD;
                end
            end
            ST_EXIT: begin
                st_d.rviol = sel_i;
                if (st_q.cnt == '0) begin
                    st_d.st  = ST_RECOV;
                    st_d.cnt = RC_LD;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            ST_RECOV: begin
                st_d.rviol = sel_i;
                if (st_q.cnt == '0) st_d.st  = ST_AWAKE;
                else                st_d.cnt = st_q.cnt - CW'(1);
            end
            default: st_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st    <= ST_AWAKE;
            st_q.cnt   <= '0;
            st_q.inval <= 1'b0;
            st_q.eviol <= 1'b0;
            st_q.rviol <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign block_o      = (st_q.st != ST_AWAKE);
    assign sleep_o      = (st_q.st == ST_ASLEEP);
    assign invalid_o    = st_q.inval;
    assign entry_viol_o = st_q.eviol;
    assign recov_viol_o = st_q.rviol;
endmodule

// File: rtl/nap_sequencer.sv
module nap_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_pin_i,
    input  logic sel_i,
    input  logic req_i,
    output logic block_o,
    output logic sleep_o,
    output logic invalid_o,
    output logic entry_viol_o,
    output logic recov_viol_o
);
    logic req_s;
    logic accept;
    logic pending;

    nap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sleep_pin_i),
        .sync_o  (req_s)
    );

    nap_inflight u_inflight (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .pending_o (pending)
    );

    nap_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s_i      (req_s),
        .sel_i        (sel_i),
        .req_i        (req_i),
        .pending_i    (pending),
        .accept_o     (accept),
        .block_o      (block_o),
        .sleep_o      (sleep_o),
        .invalid_o    (invalid_o),
        .entry_viol_o (entry_viol_o),
        .recov_viol_o (recov_viol_o)
    );
endmodule

// File: rtl/nap_checker.sv
module nap_checker #(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic block_o,
    input logic sleep_o,
    input logic invalid_o,
    input logic entry_viol_o,
    input logic recov_viol_o
);
    logic [15:0] ecnt_q, xcnt_q;
    logic        slept_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt_q  <= '0;
            xcnt_q  <= '0;
            slept_q <= 1'b0;
        end else if (!block_o) begin
            ecnt_q  <= '0;
            xcnt_q  <= '0;
            slept_q <= 1'b0;
        end else begin
            if (sleep_o) slept_q <= 1'b1;
            if (!sleep_o && !slept_q) ecnt_q <= ecnt_q + 16'd1;
            if (!sleep_o && slept_q)  xcnt_q <= xcnt_q + 16'd1;
        end
    end

    AST_SLEEP_IMPLIES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> block_o); // R5
    AST_ENTRY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> (ecnt_q == 16'(ENTRY_CYC))); // R3
    AST_EXIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(block_o) |-> (xcnt_q == 16'(EXIT_CYC + RECOV_CYC))); // R4
    AST_INVALID_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (block_o && !sleep_o && $rose(block_o))); // R6
    AST_ENTRY_VIOL_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        entry_viol_o |-> ($rose(block_o) && $past(sel_i))); // R7
    AST_RECOV_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        recov_viol_o |-> ($past(sel_i) && $past(block_o) && !$past(sleep_o))); // R8
    AST_NO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(block_o) |-> slept_q); // R9
endmodule

bind nap_sequencer nap_checker #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .RECOV_CYC (RECOV_CYC)
) i_nap_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel_i),
    .block_o      (block_o),
    .sleep_o      (sleep_o),
    .invalid_o    (invalid_o),
    .entry_viol_o (entry_viol_o),
    .recov_viol_o (recov_viol_o)
);

// File: tb/test_nap_sequencer.sv
`timescale 1ns/1ps
module test_nap_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, sel = 1'b0, req = 1'b0;
    logic block_o, sleep_o, invalid_o, entry_viol_o, recov_viol_o;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    nap_sequencer i_nap_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_pin_i  (pin),
        .sel_i        (sel),
        .req_i        (req),
        .block_o      (block_o),
        .sleep_o      (sleep_o),
        .invalid_o    (invalid_o),
        .entry_viol_o (entry_viol_o),
        .recov_viol_o (recov_viol_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic all_quiet(input string tag);
        chk({tag, " block"},  block_o,      1'b0);
        chk({tag, " sleep"},  sleep_o,      1'b0);
        chk({tag, " inval"},  invalid_o,    1'b0);
        chk({tag, " eviol"},  entry_viol_o, 1'b0);
        chk({tag, " rviol"},  recov_viol_o, 1'b0);
    endtask

    task automatic settle();
        pin = 1'b0; sel = 1'b0; req = 1'b0;
        tick(12);
    endtask

    task automatic t_reset();
        tick(1);
        all_quiet("R1 in reset");
        rst_n = 1'b1;
        tick(1);
        all_quiet("R1 after reset");
    endtask

    task automatic t_basic();
        pin = 1'b1;
        tick(2);
        chk("R2 block not yet", block_o, 1'b0);
        tick(1);
        chk("R2 block rises", block_o, 1'b1);
        chk("R3 not asleep yet", sleep_o, 1'b0);
        tick(1);
        chk("R3 still entering", sleep_o, 1'b0);
        tick(1);
        chk("R3 asleep", sleep_o, 1'b1);
        chk("R5 block asleep", block_o, 1'b1);
        sel = 1'b1;
        tick(1);
        sel = 1'b0;
        tick(1);
        chk("R8 sel asleep ignored", recov_viol_o, 1'b0);
        chk("R7 no entry viol asleep", entry_viol_o, 1'b0);
        pin = 1'b0;
        tick(2);
        chk("R4 still asleep", sleep_o, 1'b1);
        tick(1);
        chk("R4 sleep falls", sleep_o, 1'b0);
        chk("R5 block exiting", block_o, 1'b1);
        tick(3);
        chk("R5 block recovery", block_o, 1'b1);
        tick(1);
        chk("R4 block falls", block_o, 1'b0);
        settle();
    endtask

    task automatic t_entry_viol();
        pin = 1'b1; sel = 1'b1; req = 1'b1;
        tick(3);
        sel = 1'b0; req = 1'b0;
        chk("R7 entry viol pulse", entry_viol_o, 1'b1);
        chk("R6 invalid decision cycle", invalid_o, 1'b1);
        tick(1);
        chk("R7 entry viol one cycle", entry_viol_o, 1'b0);
        chk("R6 invalid one cycle", invalid_o, 1'b0);
        settle();
    endtask

    task automatic t_prior_access();
        pin = 1'b1;
        tick(1);
        sel = 1'b1; req = 1'b1;
        tick(1);
        sel = 1'b0; req = 1'b0;
        tick(1);
        chk("R6 invalid prior cycle", invalid_o, 1'b1);
        chk("R7 no viol sel low", entry_viol_o, 1'b0);
        settle();
    endtask

    task automatic t_old_access();
        pin = 1'b1; sel = 1'b1; req = 1'b1;
        tick(1);
        sel = 1'b0; req = 1'b0;
        tick(2);
        chk("R6 block entering", block_o, 1'b1);
        chk("R6 old access not invalid", invalid_o, 1'b0);
        settle();
    endtask

    task automatic t_recov();
        pin = 1'b1;
        tick(6);
        pin = 1'b0;
        tick(3);
        sel = 1'b1;
        tick(1);
        sel = 1'b0;
        chk("R8 sel in exit flagged", recov_viol_o, 1'b1);
        tick(1);
        chk("R8 flag one cycle", recov_viol_o, 1'b0);
        sel = 1'b1;
        tick(1);
        sel = 1'b0;
        chk("R8 sel in recovery flagged", recov_viol_o, 1'b1);
        chk("R5 block in recovery", block_o, 1'b1);
        tick(1);
        chk("R4 awake after recovery", block_o, 1'b0);
        chk("R8 cleared", recov_viol_o, 1'b0);
        sel = 1'b1;
        tick(1);
        sel = 1'b0;
        chk("R8 sel awake ignored", recov_viol_o, 1'b0);
        settle();
    endtask

    task automatic t_early_release();
        pin = 1'b1;
        tick(3);
        chk("R9 entering", block_o, 1'b1);
        pin = 1'b0;
        tick(2);
        chk("R9 entry completes", sleep_o, 1'b1);
        tick(1);
        chk("R9 exit begins", sleep_o, 1'b0);
        tick(3);
        chk("R9 full recovery", block_o, 1'b1);
        tick(1);
        chk("R9 awake", block_o, 1'b0);
        settle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_entry_viol();
        t_prior_access();
        t_old_access();
        t_recov();
        t_early_release();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule